// File: doc/BRIEF.md
# Ethernet Receive Preamble Hunt Detector

This block watches a serial receive bit stream, one bit per strobe, and finds where an Ethernet frame's data begins. When the receiver is enabled, carrier is present and no collision is signalled, it starts hunting. Each received bit is shifted in LSB first, and after every shift the last eight bits are compared against a programmable sync pattern. For a standard preamble and start-of-frame delimiter this pattern is 0xD5. Compare results are ignored for a selectable number of bit times after the frame starts. Once the pattern matches, the block stops hunting and assembles the following bits into bytes.

The block also screens the preamble for bit-pattern faults, and the faults it looks for depend on bit position. Two equal consecutive bits inside the 14..21 window reject the frame. Two consecutive zeros further on, before the pattern matches, also reject the frame. After a reject the detector stays quiet until carrier drops. Its outputs are a byte bus with a valid strobe, a one-cycle frame-start pulse and a one-cycle reject pulse.

Bit positions are numbered from 1, starting with the first bit strobe accepted while hunting. Each output pulse is high during the clock cycle that follows the edge at which the bit strobe causing it is sampled.

Top module: `hunt_detector`

## Requirements
- R1: While reset is high and in the first cycle after it, frame_start, frame_reject and byte_valid are low and rx_byte is zero.
- R2: Hunting starts only from idle, and only in a cycle where rx_enable and carrier are high and collision is low. A frame arriving while collision is high, or while rx_enable is low, produces no output pulse.
- R3: In hunt mode each strobed bit enters the top of an 8-bit register that shifts toward bit 0, so the earliest of the last eight bits ends up in bit 0. The register is compared with sync_pattern after every shift, and any 8-bit pattern can be matched.
- R4: A match counts only when the current bit position is at least the compare delay. delay_sel 0, 1, 2 and 3 select 0, 8, 16 and 22 bit times.
- R5: If bit p equals bit p-1 and both lie in positions 14..21 (so 15 <= p <= 21), frame_reject pulses and hunting ends. A pair ending at position 14 is not a fault. A fault on the same bit as a match wins over the match.
- R6: Two zeros at positions p-1 and p with p >= 23, seen while still hunting, reject the frame. Two ones at such positions do not.
- R7: On a valid match, frame_start pulses. The bits that follow are assembled LSB first, and byte_valid pulses with the byte on rx_byte after every eighth bit.
- R8: After a reject, bits are ignored while carrier stays high. After carrier drops, a new frame can be hunted.
- R9: If carrier or rx_enable drops while hunting or assembling, the block returns to idle and never emits a partly assembled byte.
- R10: frame_start, frame_reject and byte_valid are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | Receiver enable |
| carrier | input | 1 | Carrier sense |
| collision | input | 1 | Collision indication |
| bit_en | input | 1 | Strobe marking a valid rx_bit |
| rx_bit | input | 1 | Serial receive data bit |
| sync_pattern | input | 8 | Pattern that ends hunting |
| delay_sel | input | 2 | Compare delay select (0/8/16/22 bits) |
| rx_byte | output | 8 | Assembled byte |
| byte_valid | output | 1 | rx_byte holds a new byte |
| frame_start | output | 1 | Pattern matched; data follows |
| frame_reject | output | 1 | Preamble fault detected |

## Verification
The hardest case to reach is the late double-zero check. The stimulus has to get past bit 22 without a match and without tripping the window check, yet any "11" in an alternating stream already looks like the delimiter. The bench therefore builds bit streams whose alternation phase is picked so that the only double is the intended one. Where a double inside the window would also form a match, a long compare delay or the fault-over-match priority decides the result. The compare delay is tested with a pattern of 0x55, which matches at every even position, so the position of the frame-start pulse directly shows which delay the design applied.

// File: rtl/hunt_pkg.sv
package hunt_pkg;
    localparam int unsigned SYNC_W  = 8;
    localparam int unsigned POS_W   = 6;
    localparam int unsigned WIN_LO  = 14;
    localparam int unsigned WIN_HI  = 21;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HUNT,
        ST_ASSEMBLE,
        ST_DRAIN
    } hunt_state_e;

    function automatic int unsigned delay_bits(input logic [1:0] sel);
        case (sel)
            2'd0:    return 0;
            2'd1:    return 8;
            2'd2:    return 16;
            default: return 22;
        endcase
    endfunction
endpackage

// File: rtl/preamble_fault_chk.sv
module preamble_fault_chk #(
    parameter int unsigned POS_W = hunt_pkg::POS_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       take,
    input  logic       bit_in,
    input  logic [1:0] delay_sel,
    output logic       fault,
    output logic       cmp_ok
);
    localparam logic [POS_W-1:0] POS_MAX   = '1;
    localparam logic [POS_W-1:0] WIN_FIRST = POS_W'(hunt_pkg::WIN_LO + 1);
    localparam logic [POS_W-1:0] WIN_LAST  = POS_W'(hunt_pkg::WIN_HI);
    localparam logic [POS_W-1:0] LATE_MIN  = POS_W'(hunt_pkg::WIN_HI + 2);

    logic [POS_W-1:0] cnt;
    logic [POS_W-1:0] pos_now;
    logic [POS_W-1:0] dly;
    logic             prev;
    logic             dbl, in_win, late;

    assign pos_now = (cnt == POS_MAX) ? cnt : cnt + 1'b1;
    assign dly     = POS_W'(hunt_pkg::delay_bits(delay_sel));
    assign dbl     = (cnt != '0) && (bit_in == prev);
    assign in_win  = (pos_now >= WIN_FIRST) && (pos_now <= WIN_LAST);
    assign late    = (pos_now >= LATE_MIN);
    assign fault   = take && dbl && (in_win || (late && !bit_in));
    assign cmp_ok  = (pos_now >= dly);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt  <= '0;
            prev <= 1'b0;
        end else if (take) begin
            cnt  <= pos_now;
            prev <= bit_in;
        end
    end

    assert_pos_cleared_R4: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt == '0));
endmodule

// File: rtl/sync_shift.sv
module sync_shift #(
    parameter int unsigned W = hunt_pkg::SYNC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         take,
    input  logic         bit_in,
    input  logic [W-1:0] pattern,
    output logic         match
);
    logic [W-1:0] sh;
    logic [W-1:0] sh_next;

    assign sh_next = {bit_in, sh[W-1:1]};
    assign match   = take && (sh_next == pattern);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sh <= '0;
        end else if (take) begin
            sh <= sh_next;
        end
    end
endmodule

// File: rtl/byte_asm.sv
module byte_asm #(
    parameter int unsigned W = hunt_pkg::SYNC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         take,
    input  logic         bit_in,
    output logic [W-1:0] byte_out,
    output logic         valid
);
    localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(W - 1);

    logic [IDX_W-1:0] idx;
    logic [W-1:0]     acc;
    logic [W-1:0]     acc_next;

    assign acc_next = {bit_in, acc[W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            idx      <= '0;
            acc      <= '0;
            byte_out <= '0;
            valid    <= 1'b0;
        end else if (clear) begin
            idx   <= '0;
            acc   <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (take) begin
                acc <= acc_next;
                if (idx == IDX_LAST) begin
                    idx      <= '0;
                    byte_out <= acc_next;
                    valid    <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    assert_byte_spacing_R7: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);
endmodule

// File: rtl/hunt_detector.sv
module hunt_detector #(
    parameter int unsigned SYNC_W = hunt_pkg::SYNC_W,
    parameter int unsigned POS_W  = hunt_pkg::POS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_enable,
    input  logic              carrier,
    input  logic              collision,
    input  logic              bit_en,
    input  logic              rx_bit,
    input  logic [SYNC_W-1:0] sync_pattern,
    input  logic [1:0]        delay_sel,
    output logic [SYNC_W-1:0] rx_byte,
    output logic              byte_valid,
    output logic              frame_start,
    output logic              frame_reject
);
    import hunt_pkg::*;

    hunt_state_e state, state_nx;
    logic go, abort, hunting, assembling;
    logic take_h, take_a;
    logic fault, cmp_ok, match;
    logic hit, bad;

    assign go         = rx_enable && carrier && !collision;
    assign abort      = !rx_enable || !carrier;
    assign hunting    = (state == ST_HUNT);
    assign assembling = (state == ST_ASSEMBLE);
    assign take_h     = bit_en && hunting && !abort;
    assign take_a     = bit_en && assembling && !abort;
    assign bad        = take_h && fault;
    assign hit        = take_h && !fault && match && cmp_ok;

    preamble_fault_chk #(.POS_W(POS_W)) u_fault (
        .clk(clk), .rst(rst), .clear(!hunting), .take(take_h),
        .bit_in(rx_bit), .delay_sel(delay_sel),
        .fault(fault), .cmp_ok(cmp_ok)
    );

    sync_shift #(.W(SYNC_W)) u_sync (
        .clk(clk), .rst(rst), .clear(!hunting), .take(take_h),
        .bit_in(rx_bit), .pattern(sync_pattern), .match(match)
    );

    byte_asm #(.W(SYNC_W)) u_asm (
        .clk(clk), .rst(rst), .clear(!assembling), .take(take_a),
        .bit_in(rx_bit), .byte_out(rx_byte), .valid(byte_valid)
    );

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:     if (go) state_nx = ST_HUNT;
            ST_HUNT: begin
                if (abort)    state_nx = ST_IDLE;
                else if (bad) state_nx = ST_DRAIN;
                else if (hit) state_nx = ST_ASSEMBLE;
            end
            ST_ASSEMBLE: if (abort) state_nx = ST_IDLE;
            default:     if (!carrier) state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            frame_start  <= 1'b0;
            frame_reject <= 1'b0;
        end else begin
            state        <= state_nx;
            frame_start  <= hit;
            frame_reject <= bad;
        end
    end

    assert_pulses_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({frame_start, frame_reject, byte_valid}));

    assert_entry_gated_R2: assert property (@(posedge clk) disable iff (rst)
        (hunting && $past(state) == ST_IDLE) |-> $past(rx_enable && carrier && !collision));

    assert_start_enters_assembly_R7: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (assembling && $past(state) == ST_HUNT));

    assert_reject_enters_drain_R5: assert property (@(posedge clk) disable iff (rst)
        frame_reject |-> (state == ST_DRAIN && $past(state) == ST_HUNT));

    assert_drain_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN && carrier) |=> (state == ST_DRAIN));

    assert_byte_in_frame_R9: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> ($past(state) == ST_ASSEMBLE && $past(carrier) && $past(rx_enable)));
endmodule

// File: tb/test_hunt_detector.sv
`timescale 1ns/1ps
module test_hunt_detector;
    localparam int K_START  = 0;
    localparam int K_BYTE   = 1;
    localparam int K_REJECT = 2;

    typedef struct {
        int    kind;
        int    data;
        int    pos;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_enable = 1'b0;
    logic       carrier = 1'b0;
    logic       collision = 1'b0;
    logic       bit_en = 1'b0;
    logic       rx_bit = 1'b0;
    logic [7:0] sync_pattern = 8'hD5;
    logic [1:0] delay_sel = 2'd0;
    logic [7:0] rx_byte;
    logic       byte_valid, frame_start, frame_reject;

    exp_t exp_q[$];
    bit   bit_q[$];
    int   checks = 0;
    int   errors = 0;
    int   events = 0;
    int   bits_sent = 0;

    always #2.5 clk = ~clk;

    hunt_detector i_hunt_detector (
        .clk(clk), .rst(rst), .rx_enable(rx_enable), .carrier(carrier),
        .collision(collision), .bit_en(bit_en), .rx_bit(rx_bit),
        .sync_pattern(sync_pattern), .delay_sel(delay_sel),
        .rx_byte(rx_byte), .byte_valid(byte_valid),
        .frame_start(frame_start), .frame_reject(frame_reject)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic push(input int kind, input int data, input int pos, input string req);
        exp_t e;
        e.kind = kind; e.data = data; e.pos = pos; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic alt(input int n);
        for (int i = 0; i < n; i++) begin
            if (bit_q.size() == 0) bit_q.push_back(1'b1);
            else bit_q.push_back(!bit_q[bit_q.size()-1]);
        end
    endtask

    task automatic add_bit(input bit b);
        bit_q.push_back(b);
    endtask

    task automatic add_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) bit_q.push_back(v[i]);
    endtask

    task automatic preamble_sfd();
        alt(56);
        add_byte(8'hD5);
    endtask

    task automatic send_bit(input bit b);
        @(negedge clk);
        rx_bit = b;
        bit_en = 1'b1;
        bits_sent++;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic play();
        foreach (bit_q[i]) send_bit(bit_q[i]);
        bit_q.delete();
        repeat (2) @(negedge clk);
    endtask

    task automatic begin_frame();
        bits_sent = 0;
        @(negedge clk);
        carrier = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic end_frame();
        @(negedge clk);
        carrier = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Monitor: pops the scoreboard whenever the design raises a pulse
    always @(negedge clk) begin
        if (!rst && (frame_start || frame_reject || byte_valid)) begin
            int   kind;
            exp_t e;
            events++;
            kind = frame_start ? K_START : (frame_reject ? K_REJECT : K_BYTE);
            check($countones({frame_start, frame_reject, byte_valid}) == 1, "R10",
                  "pulses at once", $countones({frame_start, frame_reject, byte_valid}), 1);
            if (exp_q.size() == 0) begin
                check(1'b0, "R2/R8/R9", "unexpected event kind", kind, -1);
            end else begin
                e = exp_q.pop_front();
                check(kind == e.kind, e.req, "event kind", kind, e.kind);
                check(bits_sent == e.pos, e.req, "event bit position", bits_sent, e.pos);
                if (e.kind == K_BYTE)
                    check(int'(rx_byte) == e.data, e.req, "byte value", int'(rx_byte), e.data);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int ev0;
        int dpos[4];
        dpos[0] = 8; dpos[1] = 8; dpos[2] = 16; dpos[3] = 22;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: outputs idle after reset
        check({frame_start, frame_reject, byte_valid, rx_byte} == 11'd0, "R1",
              "outputs after reset", int'({frame_start, frame_reject, byte_valid, rx_byte}), 0);
        rx_enable = 1'b1;

        // R3 R7: standard preamble, delimiter and two data bytes
        begin_frame();
        preamble_sfd();
        add_byte(8'h3C);
        add_byte(8'hA7);
        push(K_START, 0, 64, "R3");
        push(K_BYTE, 8'h3C, 72, "R7");
        push(K_BYTE, 8'hA7, 80, "R7");
        play();
        end_frame();

        // R4: pattern 0x55 matches at every even position; delay picks which
        sync_pattern = 8'h55;
        for (int s = 0; s < 4; s++) begin
            delay_sel = 2'(s);
            begin_frame();
            alt(dpos[s]);
            push(K_START, 0, dpos[s], "R4");
            play();
            end_frame();
        end
        delay_sel = 2'd0;

        // R3: a pattern with an inner double one
        sync_pattern = 8'hB6;
        begin_frame();
        alt(31);
        add_byte(8'hB6);
        push(K_START, 0, 39, "R3");
        play();
        end_frame();
        sync_pattern = 8'hD5;

        // R5: double one at 17,18 rejects; it would also match, fault wins
        begin_frame();
        alt(17);
        add_bit(1'b1);
        push(K_REJECT, 0, 18, "R5");
        play();
        end_frame();

        // R5 boundary: double at 13,14 is outside the window (delay hides its match)
        delay_sel = 2'd2;
        begin_frame();
        alt(13);
        add_bit(1'b1);
        alt(41);
        add_byte(8'hD5);
        add_byte(8'h5A);
        push(K_START, 0, 63, "R5");
        push(K_BYTE, 8'h5A, 71, "R5");
        play();
        end_frame();
        delay_sel = 2'd0;

        // R6: double zero at 30,31 rejects
        begin_frame();
        alt(30);
        add_bit(1'b0);
        push(K_REJECT, 0, 31, "R6");
        play();
        // R8: carrier still high, a full frame is ignored
        ev0 = events;
        preamble_sfd();
        play();
        check(events == ev0, "R8", "events while draining", events - ev0, 0);
        end_frame();
        // R8: after carrier drop, hunting works again
        begin_frame();
        preamble_sfd();
        push(K_START, 0, 64, "R8");
        play();
        end_frame();

        // R2: collision blocks hunt entry
        collision = 1'b1;
        ev0 = events;
        begin_frame();
        preamble_sfd();
        play();
        end_frame();
        collision = 1'b0;
        check(events == ev0, "R2", "events with collision", events - ev0, 0);

        // R2: disabled receiver stays idle
        rx_enable = 1'b0;
        ev0 = events;
        begin_frame();
        preamble_sfd();
        play();
        end_frame();
        rx_enable = 1'b1;
        check(events == ev0, "R2", "events while disabled", events - ev0, 0);

        // R9: carrier lost mid byte, no partial byte
        ev0 = events;
        begin_frame();
        preamble_sfd();
        add_byte(8'h00);
        void'(bit_q.pop_back()); void'(bit_q.pop_back());
        void'(bit_q.pop_back()); void'(bit_q.pop_back());
        push(K_START, 0, 64, "R9");
        play();
        end_frame();
        check(events - ev0 == 1, "R9", "events for aborted frame", events - ev0, 1);
        begin_frame();
        preamble_sfd();
        add_byte(8'hC3);
        push(K_START, 0, 64, "R9");
        push(K_BYTE, 8'hC3, 72, "R9");
        play();
        end_frame();

        check(exp_q.size() == 0, "R7", "expected events left", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule